// File: doc/BRIEF.md
# Comparator Output Control Register

This block holds the six-bit control word of one comparator channel and applies it to the digitized comparator result. Three bits of the word act on the output path: one gates comparator power, one enables the output driver and one freezes the output level. The other three bits are general-purpose storage that the host can read back and that have no effect on the output. The analog comparator sits outside the block; its decision arrives on `cmp_raw` as a plain logic level.

The word is volatile. The first clock edge after reset loads it from data register 0, which a neighbouring store presents on `dr_bank`. After that the host can write it directly or copy any of the data registers into it. When the output driver is switched on, a settle counter keeps the driver off for a set number of cycles, which stands in for the time the comparator needs to come up. `out_drive` is meant to control a three-state pad. While it is low the pad is high impedance, and `out_data` is held at 0.

Top module: `ocr_comp_ctl`

## Requirements
- R1: While `rst_n` is low, `ctl_q`, `pwr_on`, `out_drive` and `out_data` are all 0.
- R2: On the first rising clock edge after reset is released, `ctl_q` loads data register 0, which is `dr_bank[5:0]`. This happens whatever `wr_en` and `xfer_en` are doing.
- R3: When `wr_en` is high, the next edge loads `wr_data` into `ctl_q`. A direct write wins over a transfer requested in the same cycle.
- R4: When `xfer_en` is high and `wr_en` is low, the next edge loads data register `xfer_sel` into `ctl_q`. Data register k is `dr_bank[6k+5:6k]`.
- R5: With no recall pending, `wr_en` low and `xfer_en` low, `ctl_q` keeps its value.
- R6: Bit 0 of `ctl_q` is the power control and is presented on `pwr_on`. While bit 0 is 0 and bit 2 is 0, the comparator result is taken as 0, so `out_data` is 0.
- R7: Bit 1 of `ctl_q` is the output enable. While bit 1 is 0, `out_drive` is 0. Whenever `out_drive` is 0, `out_data` is 0.
- R8: An edge that takes bit 1 from 0 to 1 starts the settle counter. `out_drive` then stays 0 after that edge and after the next SETTLE_CYC-1 edges, and it goes high after the SETTLE_CYC-th edge, provided bit 1 is still 1. Rewriting bit 1 while it is already 1 does not restart the counter.
- R9: While bit 2 of `ctl_q` is 0 and the output is driven, `out_data` follows `cmp_raw AND bit 0` in the same cycle, with no register in the path. On the edge that takes bit 2 from 0 to 1, the block captures `cmp_raw AND bit 0` as seen before that edge. `out_data` then shows the captured value for as long as bit 2 stays 1, whatever `cmp_raw` and bit 0 do.
- R10: Bits 5:3 are user bits. They read back on `ctl_q` and have no effect on `pwr_on`, `out_drive` or `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Direct write strobe |
| wr_data | input | 6 | Value for a direct write |
| xfer_en | input | 1 | Transfer strobe: copy a data register into the control word |
| xfer_sel | input | $clog2(NUM_DR) | Data register chosen for the transfer |
| dr_bank | input | 6*NUM_DR | Contents of the data registers, register k in bits [6k+5:6k] |
| cmp_raw | input | 1 | Digitized comparator decision |
| ctl_q | output | 6 | Current control word |
| pwr_on | output | 1 | Comparator power enable |
| out_drive | output | 1 | Pad driver enable (0 means high impedance) |
| out_data | output | 1 | Level to drive on the pad |

## Verification
The hardest state to reach from the ports is a held output level that differs from the live comparator result. Reaching it needs three steps in order: set the comparator input and power first, then raise the latch bit on an edge, then change the comparator input or drop power while the latch bit stays set. The directed sequence performs exactly those three steps and checks that the captured level survives both changes. The settle window is measured edge by edge after two different causes of a rising enable bit: the recall after reset and a transfer. A pseudo-random phase then mixes writes, transfers and comparator toggles, and a behavioural model is compared against the outputs every cycle.

// File: rtl/ocr_pkg.sv
package ocr_pkg;
  localparam int CTL_W = 6;
  localparam int PWR_B = 0;
  localparam int EN_B  = 1;
  localparam int LAT_B = 2;
  typedef logic [CTL_W-1:0] ctl_t;
endpackage

// File: rtl/ocr_ctl_store.sv
module ocr_ctl_store
  import ocr_pkg::*;
#(
  parameter int NUM_DR = 4,
  parameter int SEL_W  = $clog2(NUM_DR)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  ctl_t                    wr_data,
  input  logic                    xfer_en,
  input  logic [SEL_W-1:0]        xfer_sel,
  input  logic [NUM_DR*CTL_W-1:0] dr_bank,
  output ctl_t                    ctl_q,
  output ctl_t                    ctl_nx
);

  ctl_t dr_arr [NUM_DR];
  logic rcl_q;
  logic ctl_ce;
  ctl_t xfer_val;

  for (genvar k = 0; k < NUM_DR; k++) begin : g_split
    assign dr_arr[k] = dr_bank[k*CTL_W +: CTL_W];
  end

  always_comb begin
    xfer_val = '0;
    for (int k = 0; k < NUM_DR; k++) begin
      if (xfer_sel == SEL_W'(k)) xfer_val = dr_arr[k];
    end
  end

  // recall has top priority, then direct write, then transfer
  always_comb begin
    ctl_nx = ctl_q;
    if (rcl_q)        ctl_nx = dr_arr[0];
    else if (wr_en)   ctl_nx = wr_data;
    else if (xfer_en) ctl_nx = xfer_val;
  end

  assign ctl_ce = rcl_q | wr_en | xfer_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcl_q <= 1'b1;
      ctl_q <= '0;
    end else begin
      rcl_q <= 1'b0;
      if (ctl_ce) ctl_q <= ctl_nx;
    end
  end

  assert_recall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rcl_q |=> (ctl_q == $past(dr_bank[CTL_W-1:0])));

  assert_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rcl_q && wr_en) |=> (ctl_q == $past(wr_data)));

  assert_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rcl_q && !wr_en && xfer_en) |=>
      (ctl_q == $past(dr_bank[xfer_sel*CTL_W +: CTL_W])));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rcl_q && !wr_en && !xfer_en) |=> $stable(ctl_q));

endmodule

// File: rtl/ocr_settle.sv
module ocr_settle #(
  parameter int SETTLE_CYC = 16,
  parameter int CNT_W      = (SETTLE_CYC > 0) ? $clog2(SETTLE_CYC + 1) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_q,
  input  logic en_nx,
  output logic ready
);

  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             rise;
  logic             cnt_ce;

  assign rise   = en_nx & ~en_q;
  assign cnt_ce = rise | (cnt_q != '0);

  always_comb begin
    cnt_nx = cnt_q;
    if (rise)              cnt_nx = LOAD;
    else if (cnt_q != '0)  cnt_nx = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_nx;
  end

  assign ready = (cnt_q == '0);

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);

endmodule

// File: rtl/ocr_outpath.sv
module ocr_outpath (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_bit,
  input  logic en_bit,
  input  logic lat_bit,
  input  logic ready,
  input  logic cmp_raw,
  output logic pwr_on,
  output logic out_drive,
  output logic out_data
);

  logic hold_q, hold_nx, hold_ce;
  logic live;

  assign live    = pwr_bit & cmp_raw;
  assign hold_ce = ~lat_bit;
  assign hold_nx = live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= 1'b0;
    else if (hold_ce) hold_q <= hold_nx;
  end

  assign pwr_on    = pwr_bit;
  assign out_drive = en_bit & ready;
  assign out_data  = out_drive & (lat_bit ? hold_q : live);

  assert_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_bit && $past(lat_bit) && out_drive && $past(out_drive)) |-> $stable(out_data));

  assert_unpowered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_bit && !lat_bit) |-> !out_data);

endmodule

// File: rtl/ocr_comp_ctl.sv
module ocr_comp_ctl
  import ocr_pkg::*;
#(
  parameter int NUM_DR     = 4,
  parameter int SETTLE_CYC = 16,
  localparam int SEL_W     = $clog2(NUM_DR)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [5:0]              wr_data,
  input  logic                    xfer_en,
  input  logic [SEL_W-1:0]        xfer_sel,
  input  logic [NUM_DR*6-1:0]     dr_bank,
  input  logic                    cmp_raw,
  output logic [5:0]              ctl_q,
  output logic                    pwr_on,
  output logic                    out_drive,
  output logic                    out_data
);

  ctl_t ctl_cur, ctl_nx;
  logic ready;

  ocr_ctl_store #(.NUM_DR(NUM_DR), .SEL_W(SEL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .xfer_en(xfer_en), .xfer_sel(xfer_sel), .dr_bank(dr_bank),
    .ctl_q(ctl_cur), .ctl_nx(ctl_nx)
  );

  ocr_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .en_q(ctl_cur[EN_B]), .en_nx(ctl_nx[EN_B]),
    .ready(ready)
  );

  ocr_outpath u_out (
    .clk(clk), .rst_n(rst_n), .pwr_bit(ctl_cur[PWR_B]), .en_bit(ctl_cur[EN_B]),
    .lat_bit(ctl_cur[LAT_B]), .ready(ready), .cmp_raw(cmp_raw),
    .pwr_on(pwr_on), .out_drive(out_drive), .out_data(out_data)
  );

  assign ctl_q = ctl_cur;

  assert_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_cur[EN_B] |-> !out_drive);

  assert_settle_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (SETTLE_CYC > 0 && !ctl_cur[EN_B] && ctl_nx[EN_B]) |=> !out_drive);

  always_comb begin
    if (!rst_n) assert_reset_R1: assert (ctl_q == '0 && !out_drive && !out_data);
  end

endmodule

// File: tb/ocr_comp_ctl_test.sv
module ocr_comp_ctl_test;
  localparam int NUM_DR = 4;
  localparam int S      = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_data = '0;
  logic xfer_en = 1'b0;
  logic [1:0] xfer_sel = '0;
  logic [23:0] dr_bank = {6'h2B, 6'h3F, 6'h05, 6'h0B};
  logic cmp_raw = 1'b0;
  logic [5:0] ctl_q;
  logic pwr_on, out_drive, out_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  ocr_comp_ctl #(.NUM_DR(NUM_DR), .SETTLE_CYC(S)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .xfer_en(xfer_en), .xfer_sel(xfer_sel), .dr_bank(dr_bank),
    .cmp_raw(cmp_raw), .ctl_q(ctl_q), .pwr_on(pwr_on),
    .out_drive(out_drive), .out_data(out_data)
  );

  always #5 clk = ~clk;

  // behavioural model
  int m_ctl, m_hold, m_cnt, m_rcl;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = 0; m_hold = 0; m_cnt = 0; m_rcl = 1;
    end else begin
      int nx;
      nx = m_ctl;
      if (m_rcl != 0) nx = dr_bank[5:0];
      else if (wr_en) nx = wr_data;
      else if (xfer_en) nx = (dr_bank >> (6 * xfer_sel)) & 6'h3F;
      if (((m_ctl >> 2) & 1) == 0) m_hold = (m_ctl & 1) & cmp_raw;
      if (((nx >> 1) & 1) == 1 && ((m_ctl >> 1) & 1) == 0) m_cnt = S;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_ctl = nx;
      m_rcl = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      int e_drv, e_dat;
      e_drv = (((m_ctl >> 1) & 1) == 1 && m_cnt == 0) ? 1 : 0;
      if (e_drv == 0) e_dat = 0;
      else if (((m_ctl >> 2) & 1) == 1) e_dat = m_hold;
      else e_dat = (m_ctl & 1) & cmp_raw;
      chk("R5 model ctl_q", ctl_q, m_ctl);
      chk("R6 model pwr_on", pwr_on, m_ctl & 1);
      chk("R8 model out_drive", out_drive, e_drv);
      chk("R9 model out_data", out_data, e_dat);
    end
  end

  task automatic wr(logic [5:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic xf(logic [1:0] s);
    @(negedge clk); xfer_en = 1'b1; xfer_sel = s;
    @(negedge clk); xfer_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    #23;
    chk("R1 ctl_q in reset", ctl_q, 0);
    chk("R1 drive/data in reset", {pwr_on, out_drive, out_data}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R2 recall dr0", ctl_q, 6'h0B);
    chk("R8 masked after rise", out_drive, 0);
    idle(S - 1);
    chk("R8 still masked", out_drive, 0);
    idle(1);
    chk("R8 released", out_drive, 1);
    cmp_raw = 1'b1; #1;
    chk("R9 live high", out_data, 1);
    cmp_raw = 1'b0; #1;
    chk("R9 live low", out_data, 0);
    cmp_raw = 1'b1;
    wr(6'h0A); #1;
    chk("R6 power off pwr_on", pwr_on, 0);
    chk("R6 power off data", out_data, 0);
    wr(6'h0B);
    wr(6'h0F);
    cmp_raw = 1'b0; #1;
    chk("R9 held after cmp drop", out_data, 1);
    wr(6'h0E); #1;
    chk("R9 held with power off", out_data, 1);
    wr(6'h0B); #1;
    chk("R9 live after unlatch", out_data, 0);
    cmp_raw = 1'b1;
    wr(6'h3B); #1;
    chk("R10 readback", ctl_q, 6'h3B);
    chk("R10 no effect", {pwr_on, out_drive, out_data}, 3'b111);
    wr(6'h09); #1;
    chk("R7 disabled drive", out_drive, 0);
    chk("R7 disabled data", out_data, 0);
    xf(2'd3); #1;
    chk("R4 transfer dr3", ctl_q, 6'h2B);
    chk("R8 masked after transfer", out_drive, 0);
    idle(S); #1;
    chk("R8 released after transfer", out_drive, 1);
    @(negedge clk); wr_en = 1'b1; wr_data = 6'h07; xfer_en = 1'b1; xfer_sel = 2'd1;
    @(negedge clk); wr_en = 1'b0; xfer_en = 1'b0;
    chk("R3 write beats transfer", ctl_q, 6'h07);
    idle(5);
    chk("R5 idle hold", ctl_q, 6'h07);
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cmp_raw  = lf[0];
      wr_en    = (lf[4:2] == 3'b000);
      wr_data  = lf[10:5];
      xfer_en  = (lf[13:11] == 3'b111);
      xfer_sel = lf[15:14];
    end
    @(negedge clk); wr_en = 1'b0; xfer_en = 1'b0;
    idle(2);
    finish_run();
  end
endmodule